// File: doc/BRIEF.md
# Event-Counting Interrupt Timer

This block is an interrupt timer for the cartridge side of an 8-bit console memory mapper. An 8-bit prescaler drives an 8-bit main counter. Both count up or down, and the mode register chooses which event stream clocks them: CPU cycle pulses, scanline ticks or changes of the PPU read address. When the main counter wraps past its terminal value while interrupts are enabled, a level interrupt request is raised. It stays raised until software acknowledges it.

Software programs the timer through eight write-only registers, selected by a 3-bit offset. Values loaded into the prescaler and the main counter are first XORed with a key that software sets separately. The prescaler can be cut down to its three low bits, so the main counter advances every 8 prescaler clocks instead of every 256. A register write and a count event in the same cycle resolve in favour of the write. The event of that cycle is dropped.

Top module: `evt_irq_timer`

## Requirements
- R1: After reset the interrupt output is low, all registers read as zero and the mode is therefore halted with the CPU-cycle source selected.
- R2: Mode bits [7:6] give the direction: 01 counts up, 10 counts down, 00 and 11 freeze both prescaler and main counter.
- R3: Mode bits [1:0] pick the source: 0 gives one prescaler clock per cpu_tick, 1 gives eight prescaler clocks per line_tick, 3 gives no clocks; pulses of an unselected source are ignored.
- R4: With source 2, a ppu_rd strobe whose address differs from the last strobed address gives two prescaler clocks and a repeated address gives none; the last address is recorded only while source 2 is selected and starts at zero after reset.
- R5: Mode bit 2 set makes the prescaler compare mask 0x07, clear makes it 0xFF.
- R6: Counting up, each prescaler clock increments the prescaler; when (prescaler AND mask) becomes 0 the main counter increments, and reaching 0x00 while enabled raises the interrupt.
- R7: Counting down, each prescaler clock decrements the prescaler; when (prescaler AND mask) becomes the mask the main counter decrements, and reaching 0xFF while enabled raises the interrupt.
- R8: Offset 6 stores the key; offset 4 loads the prescaler with data XOR key and offset 5 loads the main counter with data XOR key.
- R9: Offset 0 sets enable from data bit 0 and, when that bit is 0, also drops a pending interrupt; offset 2 disables and drops it; offset 3 enables without dropping it. A wrap while disabled raises nothing.
- R10: A raised interrupt stays high through further counting until an acknowledging write of R9.
- R11: Offset 1 stores the mode byte; offset 7 stores a byte that has no effect on counting or on the interrupt.
- R12: In a cycle with wr_en high, the count event of that cycle is discarded and cannot raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | One CPU cycle elapsed |
| line_tick | input | 1 | One scanline elapsed |
| ppu_rd | input | 1 | PPU read strobe |
| ppu_addr | input | 14 | PPU read address |
| irq | output | 1 | Interrupt request, active high |

## Verification
A register write and a count event can land in the same cycle. The write then wins, so that cycle's event must not advance the counter or raise the interrupt. The bench provokes this by presetting the timer one tick short of a wrap. It then issues a write to the inert offset 7 together with a cpu_tick and checks that the interrupt stays low. One plain tick later it checks that the interrupt rises. The random phase mixes writes and events freely. It compares the interrupt output each cycle against a bench model that drops events in write cycles.

// File: rtl/evt_irq_timer_pkg.sv
package evt_irq_timer_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      OFS_ENABLE  = 3'd0,
      OFS_MODE    = 3'd1,
      OFS_DISABLE = 3'd2,
      OFS_ARM     = 3'd3,
      OFS_PRE     = 3'd4,
      OFS_CNT     = 3'd5,
      OFS_KEY     = 3'd6,
      OFS_PSIZE   = 3'd7
   } reg_ofs_e;

   typedef enum logic [1:0] {
      SRC_CPU  = 2'd0,
      SRC_LINE = 2'd1,
      SRC_PPU  = 2'd2,
      SRC_NONE = 2'd3
   } clk_src_e;

   localparam logic [1:0] DIR_UP   = 2'b01;
   localparam logic [1:0] DIR_DOWN = 2'b10;
endpackage

// File: rtl/evt_irq_timer_regs.sv
module evt_irq_timer_regs
   import evt_irq_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [1:0]            dir,
   output logic                  short_pre,
   output clk_src_e              src,
   output logic                  en,
   output logic                  ack,
   output logic                  ld_pre,
   output logic                  ld_cnt,
   output logic [DATA_W-1:0]     ld_val
);
   generate
      if (DATA_W < 8) begin : g_chk_w
         $error("DATA_W must hold the 8-bit mode layout");
      end
   endgenerate

   logic [DATA_W-1:0] mode_q, key_q, psize_q;
   logic              en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= '0;
         key_q   <= '0;
         psize_q <= '0;
         en_q    <= 1'b0;
      end else if (wr_en) begin
         unique case (reg_ofs_e'(wr_addr))
            OFS_ENABLE:  en_q    <= wr_data[0];
            OFS_MODE:    mode_q  <= wr_data;
            OFS_DISABLE: en_q    <= 1'b0;
            OFS_ARM:     en_q    <= 1'b1;
            OFS_KEY:     key_q   <= wr_data;
            OFS_PSIZE:   psize_q <= wr_data;
            default:     ;
         endcase
      end
   end

   assign dir       = mode_q[7:6];
   assign short_pre = mode_q[2];
   assign src       = clk_src_e'(mode_q[1:0]);
   assign en        = en_q;
   assign ack       = wr_en && ((wr_addr == OFS_ENABLE && !wr_data[0]) ||
                                wr_addr == OFS_DISABLE);
   assign ld_pre    = wr_en && (wr_addr == OFS_PRE);
   assign ld_cnt    = wr_en && (wr_addr == OFS_CNT);
   assign ld_val    = wr_data ^ key_q;

   // R11: the mode byte is kept whole; the offset-7 byte is kept and used nowhere
   assert_mode_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_MODE) |=> mode_q == $past(wr_data));
   assert_psize_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_PSIZE) |=> psize_q == $past(wr_data));
   // R9: arming sets enable
   assert_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_ARM) |=> en_q);
endmodule

// File: rtl/evt_irq_timer_event.sv
module evt_irq_timer_event
   import evt_irq_timer_pkg::*;
#(
   parameter int unsigned PPU_AW     = 14,
   parameter int unsigned LINE_STEPS = 8,
   parameter int unsigned PPU_STEPS  = 2,
   localparam int unsigned MAX_STEPS = (LINE_STEPS > PPU_STEPS) ?
                                       LINE_STEPS : ((PPU_STEPS > 1) ? PPU_STEPS : 1),
   localparam int unsigned STEP_W    = $clog2(MAX_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  clk_src_e          src,
   input  logic              cpu_tick,
   input  logic              line_tick,
   input  logic              ppu_rd,
   input  logic [PPU_AW-1:0] ppu_addr,
   output logic [STEP_W-1:0] steps
);
   generate
      if (LINE_STEPS == 0 || PPU_AW == 0) begin : g_chk
         $error("LINE_STEPS and PPU_AW must be non-zero");
      end
   endgenerate

   logic ppu_moved;

   generate
      if (PPU_STEPS > 0) begin : g_track
         logic [PPU_AW-1:0] last_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                         last_q <= '0;
            else if (src == SRC_PPU && ppu_rd)  last_q <= ppu_addr;
         end
         assign ppu_moved = ppu_rd && (ppu_addr != last_q);
      end else begin : g_notrack
         assign ppu_moved = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_CPU:  steps = cpu_tick  ? STEP_W'(1)          : '0;
         SRC_LINE: steps = line_tick ? STEP_W'(LINE_STEPS) : '0;
         SRC_PPU:  steps = ppu_moved ? STEP_W'(PPU_STEPS)  : '0;
         default:  steps = '0;
      endcase
   end

   // R3: the idle source never produces clocks
   assert_idle_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_NONE) |-> steps == '0);
   // R4: a strobe at the same address produces no clocks
   assert_ppu_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_PPU && ppu_rd && $past(src == SRC_PPU && ppu_rd) &&
       ppu_addr == $past(ppu_addr)) |-> steps == '0);
endmodule

// File: rtl/evt_irq_timer_count.sv
module evt_irq_timer_count
   import evt_irq_timer_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter int unsigned SHORT_BITS = 3,
   parameter int unsigned MAX_STEPS  = 8,
   localparam int unsigned STEP_W    = $clog2(MAX_STEPS + 1),
   localparam logic [W-1:0] SHORT_MASK = W'((1 << SHORT_BITS) - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        dir,
   input  logic              short_pre,
   input  logic [STEP_W-1:0] steps,
   input  logic              hold,
   input  logic              ld_pre,
   input  logic              ld_cnt,
   input  logic [W-1:0]      ld_val,
   output logic              hit
);
   generate
      if (SHORT_BITS == 0 || SHORT_BITS >= W) begin : g_chk
         $error("SHORT_BITS must lie between 1 and W-1");
      end
   endgenerate

   logic [W-1:0] pre_q, cnt_q, pre_n, cnt_n, mask;
   logic         up, down, hit_raw;

   assign up   = (dir == DIR_UP);
   assign down = (dir == DIR_DOWN);
   assign mask = short_pre ? SHORT_MASK : '1;

   always_comb begin
      pre_n   = pre_q;
      cnt_n   = cnt_q;
      hit_raw = 1'b0;
      for (int i = 0; i < MAX_STEPS; i++) begin
         if (i < int'(steps)) begin
            if (up) begin
               pre_n = pre_n + 1'b1;
               if ((pre_n & mask) == '0) begin
                  cnt_n = cnt_n + 1'b1;
                  if (cnt_n == '0) hit_raw = 1'b1;
               end
            end else if (down) begin
               pre_n = pre_n - 1'b1;
               if ((pre_n & mask) == mask) begin
                  cnt_n = cnt_n - 1'b1;
                  if (cnt_n == '1) hit_raw = 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else begin
         if (ld_pre)     pre_q <= ld_val;
         else if (!hold) pre_q <= pre_n;
         if (ld_cnt)     cnt_q <= ld_val;
         else if (!hold) cnt_q <= cnt_n;
      end
   end

   assign hit = hit_raw && !hold;

   // R2: a halted direction freezes both stages
   assert_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !up && !down) |=> ($stable(pre_q) && $stable(cnt_q)));
   // R8: loads take the keyed value
   assert_load_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_pre |=> pre_q == $past(ld_val));
   assert_load_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt |=> cnt_q == $past(ld_val));
   // R12: a write cycle leaves the prescaler alone unless it loads it
   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !ld_pre) |=> $stable(pre_q));
endmodule

// File: rtl/evt_irq_timer.sv
module evt_irq_timer
   import evt_irq_timer_pkg::*;
#(
   parameter int unsigned W          = 8,
   parameter int unsigned SHORT_BITS = 3,
   parameter int unsigned PPU_AW     = 14,
   parameter int unsigned LINE_STEPS = 8,
   parameter int unsigned PPU_STEPS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              cpu_tick,
   input  logic              line_tick,
   input  logic              ppu_rd,
   input  logic [PPU_AW-1:0] ppu_addr,
   output logic              irq
);
   localparam int unsigned MAX_STEPS = (LINE_STEPS > PPU_STEPS) ?
                                       LINE_STEPS : ((PPU_STEPS > 1) ? PPU_STEPS : 1);
   localparam int unsigned STEP_W    = $clog2(MAX_STEPS + 1);

   logic [1:0]        dir;
   logic              short_pre, en, ack, ld_pre, ld_cnt, hit;
   clk_src_e          src;
   logic [W-1:0]      ld_val;
   logic [STEP_W-1:0] steps;
   logic              irq_q;

   evt_irq_timer_regs #(.DATA_W(W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .dir(dir), .short_pre(short_pre), .src(src),
      .en(en), .ack(ack), .ld_pre(ld_pre), .ld_cnt(ld_cnt), .ld_val(ld_val)
   );

   evt_irq_timer_event #(
      .PPU_AW(PPU_AW), .LINE_STEPS(LINE_STEPS), .PPU_STEPS(PPU_STEPS)
   ) event_i (
      .clk(clk), .rst_n(rst_n), .src(src), .cpu_tick(cpu_tick),
      .line_tick(line_tick), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
      .steps(steps)
   );

   evt_irq_timer_count #(
      .W(W), .SHORT_BITS(SHORT_BITS), .MAX_STEPS(MAX_STEPS)
   ) count_i (
      .clk(clk), .rst_n(rst_n), .dir(dir), .short_pre(short_pre),
      .steps(steps), .hold(wr_en), .ld_pre(ld_pre), .ld_cnt(ld_cnt),
      .ld_val(ld_val), .hit(hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          irq_q <= 1'b0;
      else if (ack)        irq_q <= 1'b0;
      else if (hit && en)  irq_q <= 1'b1;
   end

   assign irq = irq_q;

   // R10: a raised request persists until acknowledged
   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack) |=> irq_q);
   // R9: an acknowledge drops the request
   assert_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq_q);
   // R9: a request only rises while enabled
   assert_rise_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_q ##1 irq_q |-> $past(en));
endmodule

// File: tb/evt_irq_timer_tb_top.sv
module evt_irq_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        cpu_tick = 1'b0, line_tick = 1'b0, ppu_rd = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic        irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0]  m_mode, m_key, m_pre, m_cnt;
   logic [13:0] m_last;
   logic        m_en, m_irq;

   always #2 clk = ~clk;

   evt_irq_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cpu_tick(cpu_tick), .line_tick(line_tick),
      .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .irq(irq)
   );

   function automatic int clocks_for(logic [7:0] mode, logic ct, logic lt,
                                     logic pv, logic [13:0] pa, logic [13:0] last);
      case (mode[1:0])
         2'd0:    return ct ? 1 : 0;
         2'd1:    return lt ? 8 : 0;
         2'd2:    return (pv && pa != last) ? 2 : 0;
         default: return 0;
      endcase
   endfunction

   task automatic model_step(logic we, logic [2:0] a, logic [7:0] d,
                             logic ct, logic lt, logic pv, logic [13:0] pa);
      int n;
      logic [7:0] msk;
      logic hit;
      n   = clocks_for(m_mode, ct, lt, pv, pa, m_last);
      msk = m_mode[2] ? 8'h07 : 8'hFF;
      hit = 1'b0;
      if (m_mode[1:0] == 2'd2 && pv) m_last = pa;
      if (we) begin
         case (a)
            3'd0: begin m_en = d[0]; if (!d[0]) m_irq = 1'b0; end
            3'd1: m_mode = d;
            3'd2: begin m_en = 1'b0; m_irq = 1'b0; end
            3'd3: m_en = 1'b1;
            3'd4: m_pre = d ^ m_key;
            3'd5: m_cnt = d ^ m_key;
            3'd6: m_key = d;
            default: ;
         endcase
      end else begin
         for (int i = 0; i < n; i++) begin
            if (m_mode[7:6] == 2'b01) begin
               m_pre++;
               if ((m_pre & msk) == 8'h00) begin
                  m_cnt++;
                  if (m_cnt == 8'h00) hit = 1'b1;
               end
            end else if (m_mode[7:6] == 2'b10) begin
               m_pre--;
               if ((m_pre & msk) == msk) begin
                  m_cnt--;
                  if (m_cnt == 8'hFF) hit = 1'b1;
               end
            end
         end
         if (hit && m_en) m_irq = 1'b1;
      end
   endtask

   task automatic cyc(logic we, logic [2:0] a, logic [7:0] d,
                      logic ct, logic lt, logic pv, logic [13:0] pa);
      wr_en = we; wr_addr = a; wr_data = d;
      cpu_tick = ct; line_tick = lt; ppu_rd = pv; ppu_addr = pa;
      @(posedge clk);
      model_step(we, a, d, ct, lt, pv, pa);
      #1;
      wr_en = 1'b0; cpu_tick = 1'b0; line_tick = 1'b0; ppu_rd = 1'b0;
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, '0);
   endtask

   task automatic tick(int k);
      for (int i = 0; i < k; i++) cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, '0);
   endtask

   task automatic chk(string req, logic exp);
      n_chk++;
      if (irq !== exp) begin
         n_bad++;
         $display("FAIL %s: irq actual %b expected %b at %0t", req, irq, exp, $time);
      end
   endtask

   task automatic preset(logic [7:0] mode, logic [7:0] cnt, logic [7:0] pre);
      wr(3'd6, 8'h00);
      wr(3'd1, mode);
      wr(3'd5, cnt);
      wr(3'd4, pre);
   endtask

   initial begin
      int unused;
      unused = $urandom(32'd20240611);
      m_mode = '0; m_key = '0; m_pre = '0; m_cnt = '0; m_last = '0;
      m_en = 1'b0; m_irq = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      chk("R1 reset", 1'b0);

      // R2: halted directions freeze counting even when enabled
      wr(3'd3, 8'h00);
      tick(300);
      chk("R2 halt 00", 1'b0);
      wr(3'd1, 8'hC0);
      tick(300);
      chk("R2 halt 11", 1'b0);

      // R6 R5: up, 3-bit prescaler, one tick short of a wrap
      preset(8'h44, 8'hFF, 8'h06);
      tick(1);
      chk("R6 before wrap", 1'b0);
      tick(1);
      chk("R6 R5 wrap up", 1'b1);
      tick(20);
      chk("R10 held", 1'b1);
      wr(3'd3, 8'h00);
      chk("R9 arm keeps", 1'b1);
      wr(3'd2, 8'h00);
      chk("R9 disable clears", 1'b0);

      // R7 R8: down, 8-bit prescaler, keyed loads
      wr(3'd1, 8'h80);
      wr(3'd6, 8'h5A);
      wr(3'd5, 8'h5B);          // cnt 0x01
      wr(3'd4, 8'h5A);          // pre 0x00
      wr(3'd3, 8'h00);
      tick(1);
      chk("R7 R8 no wrap yet", 1'b0);
      wr(3'd4, 8'h5A);          // pre 0x00 again, cnt now 0x00
      tick(1);
      chk("R7 R8 wrap down", 1'b1);
      wr(3'd0, 8'h00);
      chk("R9 enable0 clears", 1'b0);

      // R3: scanline source, cpu ticks ignored
      preset(8'h41, 8'hFF, 8'hF8);
      wr(3'd0, 8'h01);
      tick(10);
      chk("R3 cpu ignored", 1'b0);
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0, '0);
      chk("R3 line eight", 1'b1);
      wr(3'd2, 8'h00);

      // R4: ppu address changes
      preset(8'h42, 8'hFF, 8'hFE);
      wr(3'd3, 8'h00);
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 14'h0000);
      cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 14'h0000);
      chk("R4 repeat none", 1'b0);
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 14'h0123);
      chk("R4 change two", 1'b1);
      wr(3'd2, 8'h00);

      // R12 R11: write in the same cycle as a tick
      preset(8'h44, 8'hFF, 8'h07);
      wr(3'd3, 8'h00);
      cyc(1'b1, 3'd7, 8'h33, 1'b1, 1'b0, 1'b0, '0);
      chk("R12 R11 write wins", 1'b0);
      tick(1);
      chk("R12 next tick", 1'b1);
      wr(3'd2, 8'h00);

      // R3: idle source
      preset(8'h43, 8'hFF, 8'h07);
      wr(3'd3, 8'h00);
      cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 14'h0777);
      cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 1'b1, 14'h0555);
      chk("R3 idle source", 1'b0);

      // R9: wrap while disabled
      wr(3'd0, 8'h00);
      preset(8'h44, 8'hFF, 8'h07);
      tick(1);
      chk("R9 disabled wrap", 1'b0);

      // random phase against the reference
      for (int k = 0; k < 6000; k++) begin
         logic [2:0] a;
         logic [7:0] d;
         logic we;
         we = ($urandom % 7) == 0;
         a  = 3'($urandom);
         d  = 8'($urandom);
         if (a == 3'd1) d[7:6] = ($urandom % 4 == 0) ? 2'($urandom) : {1'b0, 1'b1} << ($urandom % 2);
         if ((a == 3'd0 || a == 3'd2) && ($urandom % 3 != 0)) a = 3'd3;
         cyc(we, a, d, 1'($urandom), ($urandom % 6) == 0, 1'($urandom),
             14'($urandom % 4));
         chk("R6 R7 R12 random", m_irq);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule